// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh Sequencer

This block runs refresh cycles for an asynchronous DRAM bank on a simple microcontroller bus. A one-cycle tick from an external compare-match timer asks for a refresh. The sequencer waits for the current normal bus access to finish, then takes the bus. It steps through one or two precharge states, then through two or three refresh states. It drives the active-low column and row strobes so that the column strobe always falls first, and it chooses what the address bus shows while the cycle runs.

Two configuration bits shape each cycle. One adds a second precharge state. The other adds a wait state that widens the row-strobe pulse. These bits are the only things that set the length of a cycle, and they affect nothing outside refresh. A standby request puts the DRAM into self-refresh: the column strobe drops one state before the row strobe, and both stay low until the request is withdrawn. While the DRAM refreshes itself, timer ticks are ignored. A multi-bit DRAM enable field gates everything. While that field is zero, ticks have no effect. When it is nonzero, the block asserts the run output for the refresh timer.

Top module: `dramCbrRefresh`

## Requirements
- R1: After reset, rasN and casN are 1, busy and selfRefresh are 0, and addrOut equals busAddr.
- R2: A tick sampled with the enable field nonzero, busActive 0 and no cycle in progress starts a refresh cycle on the next clock edge. The cycle keeps busy at 1 for 3 + extraPrecharge + rasStretch clock cycles in a row.
- R3: With extraPrecharge 0, casN falls at the second state of the cycle. With extraPrecharge 1, it falls at the third state.
- R4: With rasStretch 0, rasN is low for 1 state and casN for 2. With rasStretch 1, rasN is low for 2 states and casN for 3.
- R5: rasN falls exactly one state after casN falls. Both rise on the same edge, when the last refresh state ends.
- R6: While busy is 1 in a refresh cycle, addrOut shows areaStart when addrMode is 0 and the held address when addrMode is 1. At all other times, addrOut equals busAddr.
- R7: A tick that arrives while busActive is 1 is held. Its cycle begins on the first edge at which busActive is sampled 0.
- R8: At most one request can be pending. Any number of ticks during one busy or busActive period produce exactly one additional refresh cycle, and that cycle begins one idle state after the current one ends.
- R9: While dramEnable is zero, ticks are ignored. timerRun equals 1 exactly when dramEnable is nonzero.
- R10: When standbyReq is sampled 1 while idle and busActive is 0, the next state drives casN 0 and rasN 1. After that, both strobes stay 0 with selfRefresh 1 until standbyReq is sampled 0. Then both strobes return to 1 on the same edge.
- R11: Ticks during self-refresh are ignored. A pending request is discarded when self-refresh is entered, so no refresh cycle follows the exit.
- R12: The held address takes the value of busAddr only on cycles where busActive is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refTick | input | 1 | One-cycle refresh request from the compare-match timer |
| dramEnable | input | EN_W | DRAM enable field; zero disables refresh |
| extraPrecharge | input | 1 | 1 adds a second precharge state |
| rasStretch | input | 1 | 1 adds one row-strobe wait state |
| addrMode | input | 1 | 0: show areaStart during refresh; 1: show held address |
| busActive | input | 1 | A normal bus access is in progress |
| busAddr | input | ADDR_W | Address of the current normal bus cycle |
| areaStart | input | ADDR_W | Start address of the DRAM area |
| standbyReq | input | 1 | Standby request; enter and hold self-refresh |
| rasN | output | 1 | Active-low row strobe |
| casN | output | 1 | Active-low column strobe |
| addrOut | output | ADDR_W | Address bus value |
| busy | output | 1 | Refresh or self-refresh owns the DRAM |
| selfRefresh | output | 1 | DRAM is held in self-refresh |
| timerRun | output | 1 | Run enable for the external refresh timer |

## Verification
A tick driven before an edge puts the first state on the outputs one cycle later. From then on, each state shows for exactly one cycle. The bench drives inputs at the falling edge and samples one state per falling edge, so for every setting of the three configuration bits it records the exact index at which each strobe falls and rises. When busActive is held, the expected start is the first falling-edge sample after busActive is released. Self-refresh entry is checked one state at a time: a column-only state first, then both strobes low. Exit is checked one sample after the request is withdrawn.

// File: rtl/dramCbrRefresh_pkg.sv
package dramCbrRefresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE1,
    ST_PRE2,
    ST_REF1,
    ST_RWAIT,
    ST_REF2,
    ST_SCAS,
    ST_SELF
  } refState_t;

  typedef struct packed {
    logic casLow;
    logic rasLow;
    logic refDrive;
    logic busy;
    logic selfRef;
  } refStrobe_t;

endpackage

// File: rtl/dramCbrRefresh_ctl.sv
module dramCbrRefresh_ctl
  import dramCbrRefresh_pkg::*;
#(
  parameter int EN_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refTick,
  input  logic [EN_W-1:0] dramEnable,
  input  logic            extraPrecharge,
  input  logic            rasStretch,
  input  logic            busActive,
  input  logic            standbyReq,
  output refStrobe_t      strobes,
  output logic            enableOn
);

  refState_t state, stateNext;
  logic pending, pendingNext;
  logic tickOk, startRef, goSelf, inSelf;

  assign enableOn = |dramEnable;
  assign inSelf   = (state == ST_SCAS) || (state == ST_SELF);
  assign tickOk   = refTick && enableOn && !inSelf;
  assign goSelf   = (state == ST_IDLE) && standbyReq && !busActive;
  assign startRef = (state == ST_IDLE) && !standbyReq && !busActive
                    && (pending || tickOk);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (goSelf) stateNext = ST_SCAS;
                else if (startRef) stateNext = ST_PRE1;
      ST_PRE1:  stateNext = extraPrecharge ? ST_PRE2 : ST_REF1;
      ST_PRE2:  stateNext = ST_REF1;
      ST_REF1:  stateNext = rasStretch ? ST_RWAIT : ST_REF2;
      ST_RWAIT: stateNext = ST_REF2;
      ST_REF2:  stateNext = ST_IDLE;
      ST_SCAS:  stateNext = ST_SELF;
      ST_SELF:  if (!standbyReq) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    if (goSelf || startRef) pendingNext = 1'b0;
    else                    pendingNext = pending || tickOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      pending <= pendingNext;
    end
  end

  always_comb begin
    strobes = '0;
    unique case (state)
      ST_PRE1, ST_PRE2: begin
        strobes.refDrive = 1'b1;
        strobes.busy     = 1'b1;
      end
      ST_REF1: begin
        strobes.refDrive = 1'b1;
        strobes.busy     = 1'b1;
        strobes.casLow   = 1'b1;
      end
      ST_RWAIT, ST_REF2: begin
        strobes.refDrive = 1'b1;
        strobes.busy     = 1'b1;
        strobes.casLow   = 1'b1;
        strobes.rasLow   = 1'b1;
      end
      ST_SCAS: begin
        strobes.busy   = 1'b1;
        strobes.casLow = 1'b1;
      end
      ST_SELF: begin
        strobes.busy    = 1'b1;
        strobes.casLow  = 1'b1;
        strobes.rasLow  = 1'b1;
        strobes.selfRef = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/dramCbrRefresh_dp.sv
module dramCbrRefresh_dp
  import dramCbrRefresh_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  refStrobe_t        strobes,
  input  logic              addrMode,
  input  logic              busActive,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ADDR_W-1:0] areaStart,
  output logic [ADDR_W-1:0] addrOut,
  output logic              rasN,
  output logic              casN,
  output logic              busy,
  output logic              selfRefresh
);

  logic [ADDR_W-1:0] heldAddr;
  logic [ADDR_W-1:0] refAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          heldAddr <= '0;
    else if (busActive) heldAddr <= busAddr;
  end

  assign refAddr     = addrMode ? heldAddr : areaStart;
  assign addrOut     = strobes.refDrive ? refAddr : busAddr;
  assign rasN        = !strobes.rasLow;
  assign casN        = !strobes.casLow;
  assign busy        = strobes.busy;
  assign selfRefresh = strobes.selfRef;

endmodule

// File: rtl/dramCbrRefresh.sv
module dramCbrRefresh
  import dramCbrRefresh_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int EN_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [EN_W-1:0]   dramEnable,
  input  logic              extraPrecharge,
  input  logic              rasStretch,
  input  logic              addrMode,
  input  logic              busActive,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ADDR_W-1:0] areaStart,
  input  logic              standbyReq,
  output logic              rasN,
  output logic              casN,
  output logic [ADDR_W-1:0] addrOut,
  output logic              busy,
  output logic              selfRefresh,
  output logic              timerRun
);

  refStrobe_t strobes;
  logic       enableOn;

  dramCbrRefresh_ctl #(.EN_W(EN_W)) u_ctl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .dramEnable(dramEnable),
    .extraPrecharge(extraPrecharge), .rasStretch(rasStretch),
    .busActive(busActive), .standbyReq(standbyReq),
    .strobes(strobes), .enableOn(enableOn)
  );

  dramCbrRefresh_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrMode(addrMode),
    .busActive(busActive), .busAddr(busAddr), .areaStart(areaStart),
    .addrOut(addrOut), .rasN(rasN), .casN(casN), .busy(busy),
    .selfRefresh(selfRefresh)
  );

  assign timerRun = enableOn;

endmodule

// File: rtl/dramCbrRefresh_chk.sv
module dramCbrRefresh_chk #(
  parameter int EN_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            rasN,
  input logic            casN,
  input logic            busy,
  input logic            selfRefresh,
  input logic            busActive,
  input logic            standbyReq,
  input logic [EN_W-1:0] dramEnable
);

  // R5
  cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> ($past(!casN) && !casN));

  // R5
  strobes_release_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> $rose(casN));

  // R2
  idle_strobes_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (rasN && casN && !selfRefresh));

  // R10
  self_holds_strobes_chk: assert property (@(posedge clk) disable iff (!rstN)
    selfRefresh |-> (!rasN && !casN && busy));

  // R7
  no_start_during_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(busActive));

  // R9
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !$past(standbyReq)) |-> ($past(dramEnable) != '0));

endmodule

bind dramCbrRefresh dramCbrRefresh_chk #(.EN_W(EN_W)) u_chk (
  .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .busy(busy),
  .selfRefresh(selfRefresh), .busActive(busActive),
  .standbyReq(standbyReq), .dramEnable(dramEnable)
);

// File: tb/dramCbrRefresh_bench.sv
`timescale 1ns/1ps
module dramCbrRefresh_bench;

  localparam int ADDR_W = 24;
  localparam int EN_W   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0;
  logic [EN_W-1:0] dramEnable = '0;
  logic extraPrecharge = 1'b0;
  logic rasStretch = 1'b0;
  logic addrMode = 1'b0;
  logic busActive = 1'b0;
  logic [ADDR_W-1:0] busAddr = 24'h000123;
  logic [ADDR_W-1:0] areaStart = 24'h400000;
  logic standbyReq = 1'b0;
  logic rasN, casN, busy, selfRefresh, timerRun;
  logic [ADDR_W-1:0] addrOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = !clk;

  dramCbrRefresh #(.ADDR_W(ADDR_W), .EN_W(EN_W)) u_dramCbrRefresh (
    .clk(clk), .rstN(rstN), .refTick(refTick), .dramEnable(dramEnable),
    .extraPrecharge(extraPrecharge), .rasStretch(rasStretch),
    .addrMode(addrMode), .busActive(busActive), .busAddr(busAddr),
    .areaStart(areaStart), .standbyReq(standbyReq), .rasN(rasN),
    .casN(casN), .addrOut(addrOut), .busy(busy),
    .selfRefresh(selfRefresh), .timerRun(timerRun)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Watches one cycle starting at the current negedge sample (index 0 = first state).
  task automatic observe(input int span, output int busyCnt, output int casCnt,
                         output int rasCnt, output int casFirst, output int rasFirst,
                         output int rises, output bit addrOk, output bit together,
                         input logic [ADDR_W-1:0] expAddr);
    logic prevBusy, prevRas, prevCas;
    busyCnt = 0; casCnt = 0; rasCnt = 0; casFirst = -1; rasFirst = -1;
    rises = 0; addrOk = 1'b1; together = 1'b1;
    prevBusy = 1'b0; prevRas = 1'b1; prevCas = 1'b1;
    for (int i = 0; i < span; i++) begin
      if (busy) begin
        busyCnt++;
        if (addrOut != expAddr) addrOk = 1'b0;
      end
      if (busy && !prevBusy) rises++;
      if (!casN) begin casCnt++; if (casFirst < 0) casFirst = i; end
      if (!rasN) begin rasCnt++; if (rasFirst < 0) rasFirst = i; end
      if ((rasN && !prevRas) != (casN && !prevCas)) together = 1'b0;
      prevBusy = busy; prevRas = rasN; prevCas = casN;
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bc, cc, rc, cf, rf, rs, spanLen;
    bit aok, tog;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rasN && casN && !busy && !selfRefresh, "R1 strobes", {rasN, casN, busy, selfRefresh}, 4'b1100);
    chk(addrOut == busAddr, "R1 addr", addrOut, busAddr);
    rstN = 1'b1;
    @(negedge clk);

    // R9 disabled field ignores ticks
    chk(timerRun == 1'b0, "R9 timerRun off", timerRun, 0);
    refTick = 1'b1; @(negedge clk); refTick = 1'b0;
    observe(10, bc, cc, rc, cf, rf, rs, aok, tog, areaStart);
    chk(bc == 0, "R9 ignored tick", bc, 0);
    dramEnable = 3'd5;
    @(negedge clk);
    chk(timerRun == 1'b1, "R9 timerRun on", timerRun, 1);

    // Sweep of configuration bits: R2 R3 R4 R5 R6
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic [ADDR_W-1:0] expA;
      extraPrecharge = cfg[0];
      rasStretch = cfg[1];
      addrMode = cfg[2];
      busAddr = 24'h010000 + 24'(cfg * 17);
      busActive = 1'b1; @(negedge clk); busActive = 1'b0;
      expA = addrMode ? busAddr : areaStart;
      busAddr = 24'h0ABC00 + 24'(cfg);
      refTick = 1'b1; @(negedge clk); refTick = 1'b0;
      observe(10, bc, cc, rc, cf, rf, rs, aok, tog, expA);
      chk(bc == 3 + cfg[0] + cfg[1], "R2 busy length", bc, 3 + cfg[0] + cfg[1]);
      chk(rs == 1, "R2 single cycle", rs, 1);
      chk(cf == 1 + cfg[0], "R3 cas fall index", cf, 1 + cfg[0]);
      chk(cc == 2 + cfg[1], "R4 cas low length", cc, 2 + cfg[1]);
      chk(rc == 1 + cfg[1], "R4 ras low length", rc, 1 + cfg[1]);
      chk(rf == cf + 1, "R5 ras after cas", rf, cf + 1);
      chk(tog, "R5 release together", tog, 1);
      chk(aok, "R6 refresh address", aok, 1);
      chk(addrOut == busAddr, "R6 idle address", addrOut, busAddr);
    end

    // R7 tick during a normal access is held
    extraPrecharge = 1'b0; rasStretch = 1'b1; addrMode = 1'b0;
    busActive = 1'b1;
    refTick = 1'b1; @(negedge clk); refTick = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy, "R7 held while access", busy, 0);
    busActive = 1'b0;
    @(negedge clk);
    chk(busy, "R7 start after access", busy, 1);
    observe(12, bc, cc, rc, cf, rf, rs, aok, tog, areaStart);
    chk(bc == 4 && rs == 1, "R7 one cycle", bc, 4);

    // R8 several ticks during an access give one cycle
    busActive = 1'b1;
    for (int k = 0; k < 3; k++) begin
      refTick = 1'b1; @(negedge clk); refTick = 1'b0; @(negedge clk);
    end
    busActive = 1'b0;
    @(negedge clk);
    observe(16, bc, cc, rc, cf, rf, rs, aok, tog, areaStart);
    chk(rs == 1 && bc == 4, "R8 absorbed ticks", rs, 1);

    // R8 ticks during a refresh give exactly one more, after one idle state
    refTick = 1'b1; @(negedge clk); refTick = 1'b0;
    spanLen = 0;
    for (int k = 0; k < 2; k++) begin
      refTick = 1'b1; @(negedge clk); refTick = 1'b0;
      spanLen++;
    end
    // we are now at index 2 of the first cycle (length 4)
    @(negedge clk); @(negedge clk);
    chk(!busy, "R8 idle gap", busy, 0);
    @(negedge clk);
    observe(12, bc, cc, rc, cf, rf, rs, aok, tog, areaStart);
    chk(rs == 1 && bc == 4, "R8 follow-up cycle", bc, 4);
    chk(spanLen == 2, "R8 tick count", spanLen, 2);

    // R10 self-refresh entry and exit
    standbyReq = 1'b1;
    @(negedge clk);
    chk(!casN && rasN && busy && !selfRefresh, "R10 cas first", {casN, rasN, busy, selfRefresh}, 4'b0110);
    @(negedge clk);
    chk(!casN && !rasN && selfRefresh, "R10 both low", {casN, rasN, selfRefresh}, 3'b001);
    // R11 tick during self-refresh
    refTick = 1'b1; @(negedge clk); refTick = 1'b0;
    repeat (3) @(negedge clk);
    chk(!casN && !rasN && selfRefresh, "R10 held", {casN, rasN, selfRefresh}, 3'b001);
    standbyReq = 1'b0;
    @(negedge clk);
    chk(casN && rasN && !selfRefresh && !busy, "R10 exit", {casN, rasN, selfRefresh, busy}, 4'b1100);
    observe(10, bc, cc, rc, cf, rf, rs, aok, tog, areaStart);
    chk(bc == 0, "R11 no refresh after exit", bc, 0);

    // R11 pending request discarded on entry
    busActive = 1'b1;
    refTick = 1'b1; @(negedge clk); refTick = 1'b0;
    standbyReq = 1'b1; busActive = 1'b0;
    @(negedge clk);
    chk(!casN && rasN, "R11 standby wins", {casN, rasN}, 2'b01);
    repeat (2) @(negedge clk);
    standbyReq = 1'b0;
    @(negedge clk);
    observe(10, bc, cc, rc, cf, rf, rs, aok, tog, areaStart);
    chk(bc == 0, "R11 pending dropped", bc, 0);

    // R12 held address changes only while busActive
    addrMode = 1'b1; extraPrecharge = 1'b0; rasStretch = 1'b0;
    busAddr = 24'h00BEEF; busActive = 1'b1; @(negedge clk);
    busActive = 1'b0; busAddr = 24'h00CAFE; repeat (2) @(negedge clk);
    refTick = 1'b1; @(negedge clk); refTick = 1'b0;
    chk(addrOut == 24'h00BEEF, "R12 held address", addrOut, 24'h00BEEF);
    observe(6, bc, cc, rc, cf, rf, rs, aok, tog, 24'h00BEEF);
    chk(aok && bc == 3, "R12 held over cycle", bc, 3);
    chk(addrOut == 24'h00CAFE, "R12 bus address after", addrOut, 24'h00CAFE);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule